// File: doc/BRIEF.md
# Per-Line Interrupt Trigger Mode Controller

This block sits between sixteen raw interrupt request lines and a downstream interrupt controller. Two byte-wide control registers, reached through a small I/O read/write port, pick for every line whether it is sensed as a rising edge on an active-high line or as a low level on an active-low line. The low-level setting lets several devices share one line with open-drain drivers.

Every raw line passes through a two-stage synchroniser. In edge mode a rising edge sets a sticky pending flag that stays until the line's acknowledge input clears it. In level mode the pending output is the inverted synchronised line and is never latched. Five line positions are fixed to edge mode. Their control bits read as zero and ignore writes.

The register port is a plain strobe interface. A write takes effect at the clock edge on which `io_wr` is high. Read data is combinational while `io_rd` is high. There is no back-pressure and no valid/ready handshake, because every access completes in one cycle.

Top module: `irqtc_top`

## Requirements
- R1: A write with `io_addr` = 0x04D0 loads bit n of `io_wdata` into the mode bit of line n (n = 0..7). A write with `io_addr` = 0x04D1 loads bit n into the mode bit of line 8+n. The new value is in force from the clock edge that samples `io_wr`.
- R2: While `io_rd` is high at 0x04D0 or 0x04D1, `io_rdata` shows that register's stored mode bits in the same cycle. At any other time `io_rdata` is 0.
- R3: After reset every mode bit is 0, so all lines are in edge mode, and every `irq_pend` bit is 0.
- R4: The mode bits of lines 0, 1, 2, 8 and 13 are always 0 and read back as 0. Writes to those positions are ignored, so the write masks are 0xF8 at 0x04D0 and 0xDE at 0x04D1.
- R5: In edge mode (mode bit 0), a rising edge on `irq_raw[i]` sets `irq_pend[i]` at the third clock edge after the raw change: two edges in the synchroniser and one in the pending flag. The flag then stays set while the line falls and rises again.
- R6: In edge mode, `irq_ack[i]` high at a clock edge clears `irq_pend[i]` at that edge. If a synchronised rising edge is seen at the same edge, the set wins.
- R7: In level mode (mode bit 1), `irq_pend[i]` is the inverse of `irq_raw[i]` delayed by two clock edges. It follows the line in both directions and is not latched.
- R8: A write that changes a line's mode bit clears that line's sticky edge flag. A line moved to edge mode therefore shows no pending request until a new rising edge arrives.
- R9: A write to any address other than 0x04D0 and 0x04D1 leaves both registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O address of the access |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, zero when no mapped read is active |
| irq_raw | input | 16 | Raw asynchronous request lines |
| irq_ack | input | 16 | Per-line clear of the edge pending flag |
| irq_pend | output | 16 | Conditioned requests to the interrupt controller |

## Verification
The bench goes after these cases:
- An acknowledge in the same cycle as a fresh synchronised edge. If the clear wins there, the request is silently lost.
- Mode flips on a line whose edge flag is set. If the flag is not cleared, a stale request is produced after switching back to edge mode.
- Writes of all ones, which catch a forced-zero position that becomes writable and lets a fixed line turn level-sensitive.
- Writes to neighbouring addresses, which expose a loose address decode.
- Long random runs of lines, acknowledges and register accesses, compared every cycle against a behavioural model. A wrong synchroniser depth shows up there as pending changes one cycle early or late, and a latched level line shows up as a request that outlives its source.

// File: rtl/irqtc_pkg.sv
package irqtc_pkg;
  localparam int unsigned LINES  = 16;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 16;
  localparam logic [ADDR_W-1:0] BASE_ADDR = 16'h04D0;
  // Writable mode bits; zero positions are fixed edge lines.
  localparam logic [LINES-1:0] WR_MASK = 16'hDEF8;
endpackage

// File: rtl/irqtc_regs.sv
module irqtc_regs
  import irqtc_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned N  = LINES,
  parameter int unsigned DW = BYTE_W,
  parameter logic [AW-1:0] BASE = BASE_ADDR,
  parameter logic [N-1:0]  MASK = WR_MASK
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic          rd,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [N-1:0]  mode,
  output logic [N-1:0]  mode_chg
);
  localparam int unsigned NR = N / DW;

  logic [N-1:0]  mode_q, mode_d;
  logic [NR-1:0] hit;

  for (genvar r = 0; r < NR; r++) begin : g_dec
    assign hit[r] = (addr == (BASE + AW'(r)));

    // R1: a decoded write lands, masked, at the next edge
    p_wr_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && hit[r]) |=> (mode_q[r*DW +: DW] == ($past(wdata) & MASK[r*DW +: DW])));
  end

  always_comb begin
    mode_d = mode_q;
    for (int r = 0; r < NR; r++) begin
      if (wr && hit[r]) mode_d[r*DW +: DW] = wdata & MASK[r*DW +: DW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else        mode_q <= mode_d;
  end

  always_comb begin
    rdata = '0;
    for (int r = 0; r < NR; r++) begin
      if (rd && hit[r]) rdata = mode_q[r*DW +: DW];
    end
  end

  assign mode     = mode_q;
  assign mode_chg = mode_d ^ mode_q;

  // R9: no decoded write, no change
  p_no_stray_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && (|hit)) |=> $stable(mode_q));
endmodule

// File: rtl/irqtc_sync.sv
module irqtc_sync
  import irqtc_pkg::*;
#(
  parameter int unsigned N      = LINES,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);
  logic [N-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) st[s] <= '0;
    end else begin
      st[0] <= din;
      for (int s = 1; s < STAGES; s++) st[s] <= st[s-1];
    end
  end

  assign dout = st[STAGES-1];
endmodule

// File: rtl/irqtc_cond.sv
module irqtc_cond
  import irqtc_pkg::*;
#(
  parameter int unsigned N = LINES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] mode,
  input  logic [N-1:0] mode_chg,
  input  logic [N-1:0] line_s,
  input  logic [N-1:0] ack,
  output logic [N-1:0] pend
);
  for (genvar i = 0; i < N; i++) begin : g_line
    logic prev_q, sticky_q, rise;

    assign rise = line_s[i] & ~prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q   <= 1'b0;
        sticky_q <= 1'b0;
      end else begin
        prev_q <= line_s[i];
        if (mode_chg[i] || mode[i]) sticky_q <= 1'b0;
        else if (rise)              sticky_q <= 1'b1;
        else if (ack[i])            sticky_q <= 1'b0;
      end
    end

    assign pend[i] = mode[i] ? ~line_s[i] : sticky_q;

    // R5: a synchronised edge in edge mode raises the request
    p_rise_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode[i] && !mode_chg[i] && rise) |=> pend[i]);
    // R5: the request holds until cleared
    p_sticky_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode[i] && !mode_chg[i] && pend[i] && !ack[i]) |=> pend[i]);
    // R6: acknowledge clears when no new edge competes
    p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode[i] && !mode_chg[i] && ack[i] && !rise) |=> !pend[i]);
    // R8: a mode change drops the edge flag
    p_chg_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mode_chg[i] |=> !sticky_q);
  end
endmodule

// File: rtl/irqtc_top.sv
module irqtc_top
  import irqtc_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned N  = LINES,
  parameter int unsigned DW = BYTE_W,
  parameter logic [AW-1:0] BASE = BASE_ADDR,
  parameter logic [N-1:0]  MASK = WR_MASK
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] io_addr,
  input  logic          io_wr,
  input  logic          io_rd,
  input  logic [DW-1:0] io_wdata,
  output logic [DW-1:0] io_rdata,
  input  logic [N-1:0]  irq_raw,
  input  logic [N-1:0]  irq_ack,
  output logic [N-1:0]  irq_pend
);
  logic [N-1:0] mode, mode_chg, line_s;

  irqtc_regs #(.AW(AW), .N(N), .DW(DW), .BASE(BASE), .MASK(MASK)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(io_addr), .wr(io_wr), .rd(io_rd),
    .wdata(io_wdata), .rdata(io_rdata), .mode(mode), .mode_chg(mode_chg)
  );

  irqtc_sync #(.N(N), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(irq_raw), .dout(line_s)
  );

  irqtc_cond #(.N(N)) u_cond (
    .clk(clk), .rst_n(rst_n), .mode(mode), .mode_chg(mode_chg),
    .line_s(line_s), .ack(irq_ack), .pend(irq_pend)
  );

  // R2: no read strobe, bus is quiet
  p_idle_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |-> (io_rdata == '0));
  // R4: fixed positions never reach level mode
  p_fixed_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode & ~MASK) == '0);
endmodule

// File: tb/sim_irqtc_top.sv
`timescale 1ns/100ps
module sim_irqtc_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] io_addr = 0;
  logic        io_wr = 0, io_rd = 0;
  logic [7:0]  io_wdata = 0;
  logic [7:0]  io_rdata;
  logic [15:0] irq_raw = 0, irq_ack = 0, irq_pend;

  int nchk = 0, nerr = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irqtc_top u0 (.clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
    .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .irq_raw(irq_raw), .irq_ack(irq_ack), .irq_pend(irq_pend));

  // behavioural reference
  logic [15:0] m_mode = 0, m_s1 = 0, m_s2 = 0, m_prev = 0, m_pend = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_s1 = 0; m_s2 = 0; m_prev = 0; m_pend = 0;
    end else begin
      logic [15:0] nm;
      nm = m_mode;
      if (io_wr && io_addr == 16'h04D0) nm[7:0]  = io_wdata & 8'hF8;
      if (io_wr && io_addr == 16'h04D1) nm[15:8] = io_wdata & 8'hDE;
      for (int i = 0; i < 16; i++) begin
        if (nm[i] != m_mode[i] || m_mode[i]) m_pend[i] = 0;
        else if (m_s2[i] && !m_prev[i])      m_pend[i] = 1;
        else if (irq_ack[i])                 m_pend[i] = 0;
      end
      m_prev = m_s2; m_s2 = m_s1; m_s1 = irq_raw; m_mode = nm;
    end
  end

  function automatic logic [15:0] exp_pend();
    logic [15:0] e;
    for (int i = 0; i < 16; i++) e[i] = m_mode[i] ? ~m_s2[i] : m_pend[i];
    return e;
  endfunction

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s got=%h exp=%h t=%0t", tag, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always begin
    @(negedge clk); #1;
    if (rst_n && !done) begin
      logic [15:0] e;
      e = exp_pend();
      nchk++;
      if (irq_pend !== e) begin
        nerr++;
        for (int i = 0; i < 16; i++)
          if (irq_pend[i] !== e[i])
            $display("FAIL %s line %0d got=%b exp=%b t=%0t",
                     m_mode[i] ? "R7" : "R5", i, irq_pend[i], e[i], $time);
      end
    end
  end

  task automatic settle(int n); repeat (n) @(negedge clk); #1; endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk); #2; io_addr = a; io_wdata = d; io_wr = 1;
    @(negedge clk); #2; io_wr = 0;
  endtask

  task automatic rd_chk(string tag, logic [15:0] a, logic [7:0] exp);
    @(negedge clk); #2; io_addr = a; io_rd = 1; #1;
    chk(tag, {8'h0, io_rdata}, {8'h0, exp});
    io_rd = 0;
  endtask

  task automatic set_raw(logic [15:0] v);
    @(negedge clk); #2; irq_raw = v;
  endtask

  task automatic ack_pulse(logic [15:0] v);
    @(negedge clk); #2; irq_ack = v;
    @(negedge clk); #2; irq_ack = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1; nchk++; nerr++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    #2 rst_n = 1;
    settle(1);
    chk("R3 pend after reset", irq_pend, 16'h0);
    rd_chk("R3 low reg reset", 16'h04D0, 8'h00);
    rd_chk("R3 high reg reset", 16'h04D1, 8'h00);

    wr(16'h04D0, 8'hFF);
    rd_chk("R1 R4 low reg mask", 16'h04D0, 8'hF8);
    wr(16'h04D1, 8'hFF);
    rd_chk("R1 R4 high reg mask", 16'h04D1, 8'hDE);
    wr(16'h04D2, 8'h00);
    wr(16'h04CF, 8'h00);
    rd_chk("R9 low reg unchanged", 16'h04D0, 8'hF8);
    rd_chk("R9 high reg unchanged", 16'h04D1, 8'hDE);
    rd_chk("R2 unmapped read", 16'h04D3, 8'h00);
    chk("R2 idle rdata", {8'h0, io_rdata}, 16'h0);
    wr(16'h04D0, 8'h00);
    wr(16'h04D1, 8'h00);
    settle(3);

    // R5: edge on line 4
    set_raw(16'h0010);
    settle(2);
    chk("R5 not yet pending", irq_pend & 16'h0010, 16'h0);
    settle(1);
    chk("R5 pending after sync", irq_pend & 16'h0010, 16'h0010);
    set_raw(16'h0000);
    settle(4);
    chk("R5 sticky after fall", irq_pend & 16'h0010, 16'h0010);
    ack_pulse(16'h0010);
    settle(1);
    chk("R6 ack clears", irq_pend & 16'h0010, 16'h0);

    // R8: line 5 pending, mode flipped twice
    set_raw(16'h0020);
    settle(4);
    chk("R8 setup pending", irq_pend & 16'h0020, 16'h0020);
    wr(16'h04D0, 8'h20);
    wr(16'h04D0, 8'h00);
    settle(2);
    chk("R8 flag dropped", irq_pend & 16'h0020, 16'h0);
    set_raw(16'h0000);

    // R7: line 9 level mode
    wr(16'h04D1, 8'h02);
    settle(1);
    chk("R7 low line pends", irq_pend & 16'h0200, 16'h0200);
    set_raw(16'h0200);
    settle(1);
    chk("R7 sync latency", irq_pend & 16'h0200, 16'h0200);
    settle(1);
    chk("R7 high line idle", irq_pend & 16'h0200, 16'h0);
    set_raw(16'h0000);
    settle(2);
    chk("R7 follows again", irq_pend & 16'h0200, 16'h0200);

    // random traffic, checked every cycle by the model
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk); #2;
      irq_raw = irq_raw ^ (16'($urandom) & 16'($urandom) & 16'($urandom));
      irq_ack = 16'($urandom) & 16'($urandom);
      io_wr = ($urandom % 16) == 0;
      io_addr = 16'h04CF + 16'($urandom % 4);
      io_wdata = 8'($urandom);
      io_rd = !io_wr && ($urandom % 4 == 0);
      #1;
      if (io_rd)
        chk("R2 random read", {8'h0, io_rdata},
            {8'h0, io_addr == 16'h04D0 ? m_mode[7:0] :
                   io_addr == 16'h04D1 ? m_mode[15:8] : 8'h00});
    end
    @(negedge clk); #2; io_wr = 0; io_rd = 0; irq_ack = 0;
    settle(3);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule